// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Unit

This unit turns a logical address (a 16-bit segment selector and an offset) into a linear address. It works in one of two modes, chosen for each request. In real mode the selector is treated as a paragraph number: it is shifted left by four and added to the low 16 bits of the offset. The 20-bit result is ready one cycle after the request, and no memory is touched.

In protected mode the selector picks an 8-byte segment descriptor from one of two descriptor tables, global or local. The unit reads the descriptor as two 32-bit words over a valid/ready read port. It then rebuilds the segment base and limit from their split fields, checks the offset against the limit, and adds the base to the offset. A flat setup (base 0, limit covering all of the 4 GB space) passes every offset through unchanged.

Only one request is handled at a time. A done strobe marks the result, and a fault flag reports a limit violation.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `done_o`, `limit_fault_o` and `mem_req_o` are 0 and `lin_addr_o` is 0.
- R2: A real-mode request (`prot_mode_i`=0) raises `done_o` in the cycle after the request. `lin_addr_o[19:0]` is (selector×16 + offset[15:0]), `lin_addr_o[31:20]` is 0, offset bits [31:16] are ignored, and `mem_req_o` stays low.
- R3: A real-mode sum beyond 20 bits drops its carry (selector FFFF, offset FFFF gives 0FFEF).
- R4: A protected-mode request reads the descriptor at table base + selector[15:3]×8 and then at that address + 4. Selector bit 2 = 1 picks `ldt_base_i`, and bit 2 = 0 picks `gdt_base_i`.
- R5: While `mem_req_o` is high and `mem_ready_i` is low, `mem_req_o` stays high and `mem_addr_o` holds its value. A word is taken in the cycle where both are high.
- R6: The descriptor layout is as follows. The first word carries limit[15:0] in [15:0] and base[15:0] in [31:16]. The second word carries base[23:16] in [7:0], limit[19:16] in [19:16], the granularity flag in [23] and base[31:24] in [31:24]. Bits [15:8] and [22:20] are ignored.
- R7: With no fault, the protected result is base + offset modulo 2^32.
- R8: With the granularity flag set, the effective limit is limit×4096 + 4095. With the flag clear, it is the 20-bit limit in bytes.
- R9: An offset above the effective limit gives `done_o` with `limit_fault_o`=1 and `lin_addr_o`=0. An offset equal to the limit does not fault.
- R10: A request that arrives while a descriptor fetch is in progress is ignored and produces no `done_o`.
- R11: `limit_fault_o` is high only while `done_o` is high, and `done_o` lasts one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, sampled while idle |
| prot_mode_i | input | 1 | 1 = protected mode, 0 = real mode |
| selector_i | input | 16 | Segment value or selector |
| offset_i | input | 32 | Offset |
| gdt_base_i | input | 32 | Global descriptor table base |
| ldt_base_i | input | 32 | Local descriptor table base |
| mem_req_o | output | 1 | Descriptor read valid |
| mem_addr_o | output | 32 | Descriptor read byte address |
| mem_ready_i | input | 1 | Read ready; data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Result strobe |
| lin_addr_o | output | 32 | Linear address, valid with done_o |
| limit_fault_o | output | 1 | Limit violation, valid with done_o |

## Verification
The hardest situation to reach is a request that lands in the middle of a stalled descriptor fetch. The bench's memory model inserts several wait cycles before it answers. During that window the stimulus fires a real-mode request, and the bench then confirms that the number of done strobes matches the number of accepted requests. The bench also places the offset exactly on the effective limit and one past it, in both granularity settings. It loads the same table index with different contents in the two tables, so a wrong table choice shows up in the result.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD_LO = 2'd1,
        ST_RD_HI = 2'd2
    } xl_state_e;

    localparam int DESC_WORD_BYTES = 4;
    localparam int REAL_SHIFT      = 4;
endpackage

// File: rtl/seg_real_calc.sv
module seg_real_calc #(
    parameter int SEG_W      = 16,
    parameter int REAL_OFS_W = 16,
    parameter int REAL_W     = 20
) (
    input  logic [SEG_W-1:0]      seg_i,
    input  logic [REAL_OFS_W-1:0] ofs_i,
    output logic [REAL_W-1:0]     lin_o
);
    import seg_xlate_pkg::*;

    logic [REAL_W-1:0] seg_shifted;
    logic [REAL_W-1:0] ofs_ext;

    always_comb begin
        seg_shifted = REAL_W'(seg_i) << REAL_SHIFT;
        ofs_ext     = REAL_W'(ofs_i);
        lin_o       = seg_shifted + ofs_ext;
    end
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack #(
    parameter int GRAN_SHIFT = 12
) (
    input  logic [31:0] lo_word_i,
    input  logic [31:0] hi_word_i,
    output logic [31:0] base_o,
    output logic [31:0] limit_o
);
    localparam logic [31:0] GRAN_FILL = (32'd1 << GRAN_SHIFT) - 32'd1;

    logic [19:0] raw_limit;
    logic        gran;
    logic        unused_bits;

    always_comb begin
        raw_limit = {hi_word_i[19:16], lo_word_i[15:0]};
        gran      = hi_word_i[23];
        base_o    = {hi_word_i[31:24], hi_word_i[7:0], lo_word_i[31:16]};
        if (gran) begin
            limit_o = ({12'd0, raw_limit} << GRAN_SHIFT) | GRAN_FILL;
        end else begin
            limit_o = {12'd0, raw_limit};
        end
    end

    assign unused_bits = ^{hi_word_i[22:20], hi_word_i[15:8]};
endmodule

// File: rtl/seg_bound_add.sv
module seg_bound_add #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] limit_i,
    input  logic [ADDR_W-1:0] offset_i,
    output logic              fault_o,
    output logic [ADDR_W-1:0] lin_o
);
    always_comb begin
        fault_o = offset_i > limit_i;
        lin_o   = fault_o ? '0 : (base_i + offset_i);
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
    parameter int ADDR_W      = 32,
    parameter int SEL_W       = 16,
    parameter int REAL_W      = 20,
    parameter int REAL_OFS_W  = 16,
    parameter int DESC_LOG2   = 3,
    parameter int GRAN_SHIFT  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              prot_mode_i,
    input  logic [SEL_W-1:0]  selector_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [ADDR_W-1:0] gdt_base_i,
    input  logic [ADDR_W-1:0] ldt_base_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ready_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] lin_addr_o,
    output logic              limit_fault_o
);
    import seg_xlate_pkg::*;

    localparam int TI_BIT  = DESC_LOG2 - 1;
    localparam int IDX_W   = SEL_W - DESC_LOG2;

    typedef struct packed {
        xl_state_e         state;
        logic [ADDR_W-1:0] desc_addr;
        logic [ADDR_W-1:0] offset;
        logic [31:0]       word_lo;
        logic              done;
        logic              fault;
        logic [ADDR_W-1:0] lin;
        logic              was_real;
    } xl_regs_t;

    xl_regs_t r_q, r_d;

    logic [REAL_W-1:0] real_lin;
    logic [ADDR_W-1:0] seg_base;
    logic [ADDR_W-1:0] seg_limit;
    logic              bound_fault;
    logic [ADDR_W-1:0] bound_lin;
    logic [ADDR_W-1:0] table_base;
    logic [ADDR_W-1:0] index_off;
    logic              unused_sel;

    seg_real_calc #(
        .SEG_W(SEL_W), .REAL_OFS_W(REAL_OFS_W), .REAL_W(REAL_W)
    ) u_real (
        .seg_i(selector_i),
        .ofs_i(offset_i[REAL_OFS_W-1:0]),
        .lin_o(real_lin)
    );

    seg_desc_unpack #(.GRAN_SHIFT(GRAN_SHIFT)) u_unpack (
        .lo_word_i(r_q.word_lo),
        .hi_word_i(mem_rdata_i),
        .base_o   (seg_base),
        .limit_o  (seg_limit)
    );

    seg_bound_add #(.ADDR_W(ADDR_W)) u_bound (
        .base_i  (seg_base),
        .limit_i (seg_limit),
        .offset_i(r_q.offset),
        .fault_o (bound_fault),
        .lin_o   (bound_lin)
    );

    assign unused_sel = ^selector_i[TI_BIT-1:0];

    always_comb begin
        table_base = selector_i[TI_BIT] ? ldt_base_i : gdt_base_i;
        index_off  = ADDR_W'(selector_i[SEL_W-1 -: IDX_W]) << DESC_LOG2;

        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    if (prot_mode_i) begin
                        r_d.desc_addr = table_base + index_off;
                        r_d.offset    = offset_i;
                        r_d.state     = ST_RD_LO;
                    end else begin
                        r_d.done     = 1'b1;
                        r_d.lin      = ADDR_W'(real_lin);
                        r_d.was_real = 1'b1;
                    end
                end
            end
            ST_RD_LO: begin
                if (mem_ready_i) begin
                    r_d.word_lo   = mem_rdata_i;
                    r_d.desc_addr = r_q.desc_addr + ADDR_W'(DESC_WORD_BYTES);
                    r_d.state     = ST_RD_HI;
                end
            end
            ST_RD_HI: begin
                if (mem_ready_i) begin
                    r_d.done     = 1'b1;
                    r_d.fault    = bound_fault;
                    r_d.lin      = bound_lin;
                    r_d.was_real = 1'b0;
                    r_d.state    = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_o     = (r_q.state != ST_IDLE);
    assign mem_addr_o    = r_q.desc_addr;
    assign done_o        = r_q.done;
    assign lin_addr_o    = r_q.lin;
    assign limit_fault_o = r_q.fault;

    // Real-mode latency: accepted in idle, result next cycle
    assert_real_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && req_i && !prot_mode_i) |=> (done_o && !mem_req_o));

    // Real-mode result stays inside the 20-bit space
    assert_real_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && r_q.was_real) |-> (lin_addr_o[ADDR_W-1:REAL_W] == '0));

    // Second descriptor word follows the first at +4
    assert_second_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RD_LO && mem_ready_i) |=>
            (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(DESC_WORD_BYTES)));

    // Read request held steady until accepted
    assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // A fault never reports an address
    assert_fault_no_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        limit_fault_o |-> (lin_addr_o == '0));

    // Fault flag only together with done
    assert_fault_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        limit_fault_o |-> done_o);

    // Busy requests are not accepted: no done while fetching the first word
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RD_LO) |=> !done_o);
endmodule

// File: tb/seg_xlate_test.sv
`timescale 1ns/100ps
module seg_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        prot_mode_i = 1'b0;
    logic [15:0] selector_i = '0;
    logic [31:0] offset_i = '0;
    logic [31:0] gdt_base_i = 32'h0000_0100;
    logic [31:0] ldt_base_i = 32'h0000_0200;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_ready_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        done_o;
    logic [31:0] lin_addr_o;
    logic        limit_fault_o;

    always #2.5 clk = ~clk;

    seg_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .prot_mode_i(prot_mode_i),
        .selector_i(selector_i), .offset_i(offset_i),
        .gdt_base_i(gdt_base_i), .ldt_base_i(ldt_base_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
        .done_o(done_o), .lin_addr_o(lin_addr_o), .limit_fault_o(limit_fault_o)
    );

    typedef struct {
        logic [31:0] lin;
        logic        fault;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] addr_q[$];
    logic [31:0] mem [0:255];
    int          n_checks = 0;
    int          n_fails = 0;
    int          n_done = 0;
    int          n_accepted = 0;
    int          wait_cfg = 0;
    bit          finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R6 layout used to build table entries
    task automatic put_desc(input logic [31:0] tbase, input int idx, input logic [31:0] base,
                            input logic [19:0] limit, input bit gran);
        int w = int'((tbase + 32'(idx * 8)) >> 2);
        mem[w]     = {base[15:0], limit[15:0]};
        mem[w + 1] = {base[31:24], gran, 3'b101, limit[19:16], 8'h92, base[23:16]};
    endtask

    task automatic real_req(input logic [15:0] seg, input logic [31:0] ofs,
                            input logic [19:0] exp_lin, input string tag);
        exp_t e;
        e.lin = {12'd0, exp_lin}; e.fault = 1'b0; e.tag = tag;
        @(negedge clk);
        req_i = 1'b1; prot_mode_i = 1'b0; selector_i = seg; offset_i = ofs;
        exp_q.push_back(e);
        n_accepted++;
        @(negedge clk);
        req_i = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic prot_req(input logic [15:0] sel, input logic [31:0] ofs, input logic [31:0] base,
                            input logic [19:0] limit, input bit gran, input string tag,
                            input bit poke_busy);
        exp_t        e;
        logic [31:0] eff;
        logic [31:0] da;
        eff = gran ? ({12'd0, limit} << 12) | 32'hFFF : {12'd0, limit};
        e.fault = ofs > eff;
        e.lin   = e.fault ? 32'd0 : base + ofs;
        e.tag   = tag;
        da = (sel[2] ? ldt_base_i : gdt_base_i) + {16'd0, sel[15:3], 3'b000};
        @(negedge clk);
        req_i = 1'b1; prot_mode_i = 1'b1; selector_i = sel; offset_i = ofs;
        exp_q.push_back(e);
        addr_q.push_back(da);
        addr_q.push_back(da + 32'd4);
        n_accepted++;
        @(negedge clk);
        req_i = 1'b0;
        if (poke_busy) begin
            // R10: a real-mode request while the fetch is stalled must be dropped
            @(negedge clk);
            req_i = 1'b1; prot_mode_i = 1'b0; selector_i = 16'h1234; offset_i = 32'h5;
            @(negedge clk);
            req_i = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Memory model with programmable wait states; checks R4 addresses and R5 hold
    initial begin
        int          cnt = 0;
        logic [31:0] held = '0;
        forever begin
            @(negedge clk);
            if (mem_ready_i) begin
                mem_ready_i = 1'b0;
                cnt = 0;
            end else if (mem_req_o) begin
                if (cnt == 0) begin
                    logic [31:0] ea;
                    ea = (addr_q.size() != 0) ? addr_q.pop_front() : 32'hDEAD_BEEF;
                    check(mem_addr_o == ea, "R4 descriptor address", mem_addr_o, ea);
                    held = mem_addr_o;
                end else begin
                    check(mem_addr_o == held, "R5 address hold", mem_addr_o, held);
                end
                if (cnt >= wait_cfg) begin
                    mem_ready_i = 1'b1;
                    mem_rdata_i = mem[mem_addr_o[9:2]];
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                n_done++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected done", lin_addr_o, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(lin_addr_o == e.lin, e.tag, lin_addr_o, e.lin);
                    check(limit_fault_o == e.fault, {e.tag, " fault flag"},
                          {31'd0, limit_fault_o}, {31'd0, e.fault});
                end
            end else if (rst_n) begin
                // R11: fault only together with done
                if (limit_fault_o) check(1'b0, "R11 stray fault", 32'd1, 32'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        put_desc(32'h100, 1, 32'h0012_0000, 20'h0FFFF, 1'b0);
        put_desc(32'h100, 2, 32'h0080_0000, 20'hFFFFF, 1'b0);
        put_desc(32'h200, 2, 32'h0040_0000, 20'h00100, 1'b0);
        put_desc(32'h100, 3, 32'h0000_0000, 20'hFFFFF, 1'b1);
        put_desc(32'h100, 4, 32'hF000_0000, 20'hFFFFF, 1'b1);
        put_desc(32'h100, 5, 32'h0000_1000, 20'h00002, 1'b1);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 1'b0, "R1 done after reset", {31'd0, done_o}, 32'd0);
        check(limit_fault_o == 1'b0, "R1 fault after reset", {31'd0, limit_fault_o}, 32'd0);
        check(mem_req_o == 1'b0, "R1 mem_req after reset", {31'd0, mem_req_o}, 32'd0);
        check(lin_addr_o == 32'd0, "R1 address after reset", lin_addr_o, 32'd0);

        real_req(16'h08F1, 32'h0000_0100, 20'h09010, "R2 real basic");
        real_req(16'h028F, 32'h0000_0030, 20'h02920, "R2 real second");
        real_req(16'h08F1, 32'hABCD_0100, 20'h09010, "R2 real upper offset ignored");
        real_req(16'hFFFF, 32'h0000_FFFF, 20'h0FFEF, "R3 real carry dropped");

        wait_cfg = 0;
        prot_req(16'h0008, 32'h0000_1234, 32'h0012_0000, 20'h0FFFF, 1'b0, "R7 gdt entry", 1'b0);
        prot_req(16'h0010, 32'h0000_0040, 32'h0080_0000, 20'hFFFFF, 1'b0, "R4 gdt index 2", 1'b0);
        prot_req(16'h0014, 32'h0000_0040, 32'h0040_0000, 20'h00100, 1'b0, "R4 ldt index 2", 1'b0);
        wait_cfg = 3;
        prot_req(16'h0014, 32'h0000_0100, 32'h0040_0000, 20'h00100, 1'b0, "R9 offset at limit", 1'b0);
        prot_req(16'h0014, 32'h0000_0101, 32'h0040_0000, 20'h00100, 1'b0, "R9 offset past limit", 1'b0);
        prot_req(16'h0018, 32'hFFFF_FFFF, 32'h0000_0000, 20'hFFFFF, 1'b1, "R6 flat segment", 1'b0);
        wait_cfg = 1;
        prot_req(16'h0020, 32'h2000_0000, 32'hF000_0000, 20'hFFFFF, 1'b1, "R7 sum wraps", 1'b0);
        prot_req(16'h0028, 32'h0000_2FFF, 32'h0000_1000, 20'h00002, 1'b1, "R8 scaled limit edge", 1'b0);
        prot_req(16'h0028, 32'h0000_3000, 32'h0000_1000, 20'h00002, 1'b1, "R8 scaled limit exceeded", 1'b0);
        wait_cfg = 4;
        prot_req(16'h0008, 32'h0000_0010, 32'h0012_0000, 20'h0FFFF, 1'b0, "R10 busy fetch result", 1'b1);
        real_req(16'h0001, 32'h0000_0001, 20'h00011, "R2 real after busy");

        repeat (5) @(negedge clk);
        check(n_done == n_accepted, "R11 one done per request", n_done, n_accepted);
        check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule